// File: doc/BRIEF.md
# Switch-to-CPU Extraction Header Stripper

This block sits between a switch core and a CPU-facing Ethernet port. Every frame arrives on a byte-wide AXI4-Stream input. A 16-byte framing prefix comes first, then a 28-byte internal header. The block checks the prefix and pulls six fields out of the header: source port, priority class, tag kind, VLAN tag control word, pop count and type offset. It drops the prefix, the header and any filler bytes that the switch left behind after popping tags. What remains is the bare Ethernet frame, which it forwards on a byte-wide AXI4-Stream output. The decoded fields travel alongside on a sideband that is valid from the first output byte to the last.

Each source port has a filter-enable bit. When that bit is set and the frame carries a VLAN tag whose protocol identifier matches the header's tag kind, the block removes the 4 tag bytes. It then flags that the header's tag control word stands for the frame's VLAN. The block drops a frame whole and pulses an error if the prefix is malformed or the frame ends too early.

Top module: `xtr_hdr_strip`

## Requirements
- R1: Only the bytes that follow the prefix, the header and the filler are emitted, in order, and `m_tlast` marks the last of them.
- R2: Prefix bytes 0 to 5 must be 0xFF, and prefix bytes 12 and 13 must be 0x88 and 0x80. The other prefix bytes are not checked. A frame that fails the check produces no output, and `frame_err` is high for exactly one cycle.
- R3: Header bytes are counted from 0, and the most significant bit of header byte 0 is header bit 223. The sideband carries source port = bits 143:140, class = bits 96:94, tag control = bits 118:103, tag kind = bit 119, pop count = bits 147:146 and type offset = bits 145:144.
- R4: The number of filler bytes skipped after the header depends on the header fields. It is 8 when pop count and type offset are both 0. It is 4 when pop count is 3. In all other cases it is 0.
- R5: `sb_valid` is low after reset. It is high in the cycle of the first output byte, and it stays high with unchanged fields until the output handshake that carries `m_tlast`.
- R6: Tag kind 0 selects protocol ID 0x8100 and tag kind 1 selects 0x88A8. The tag is removed when all of these hold: `vlan_filt[source port]` is 1, Ethernet bytes 12 and 13 equal the selected protocol ID, and the frame has at least 17 Ethernet bytes. Removal takes out Ethernet bytes 12 to 15. `sb_vlan_hdr` then goes high and stays high until the end of the frame.
- R7: If a frame is not stripped, its Ethernet bytes pass unchanged and `sb_vlan_hdr` stays low. This includes a frame that ends within the 4 bytes after the MAC addresses.
- R8: A frame that ends on or before the last filler byte produces no output and gives one `frame_err` pulse.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tdata` and `m_tlast` hold steady, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | 8 | Input stream byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tlast | input | 1 | Last byte of input frame |
| s_tready | output | 1 | Block accepts input byte |
| m_tdata | output | 8 | Output stream byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tlast | output | 1 | Last byte of output frame |
| m_tready | input | 1 | Downstream accepts output byte |
| vlan_filt | input | 16 | Per-source-port VLAN filtering enable |
| sb_valid | output | 1 | Sideband valid for current output frame |
| sb_port | output | 4 | Decoded source port |
| sb_qos | output | 3 | Decoded priority class |
| sb_tag_type | output | 1 | Decoded tag kind (0: 0x8100, 1: 0x88A8) |
| sb_tci | output | 16 | Decoded tag control word |
| sb_pop | output | 2 | Decoded pop count |
| sb_eofs | output | 2 | Decoded type offset |
| sb_vlan_hdr | output | 1 | In-frame tag removed; `sb_tci` is the frame's VLAN |
| frame_err | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
Some properties are checked by assertions on every cycle. Output bytes never appear without a valid sideband. Sideband fields stay frozen until the last output byte. A stalled output byte and its last flag stay stable. Error pulses never occur while a frame is being emitted, and the tag-removed flag never appears outside a frame.

Other behaviour only the bench scenarios can show, because it depends on the byte values: which bytes are skipped for each pop-count and type-offset combination, whether a tag is removed or replayed, the exact field bit positions, and the drop-and-error handling of bad or truncated frames.

// File: rtl/xtr_pkg.sv
package xtr_pkg;
    localparam int PFX_BYTES  = 16;
    localparam int HDR_BYTES  = 28;
    localparam int HDR_MSB    = HDR_BYTES * 8 - 1;
    localparam int MAC_BYTES  = 12;
    localparam int TAG_BYTES  = 4;
    localparam int GAP_TWO    = 2 * TAG_BYTES;
    localparam int PORT_W     = 4;
    localparam int N_PORTS    = 1 << PORT_W;
    localparam int CNT_W      = $clog2(HDR_BYTES);

    localparam int POS_PORT = 140;
    localparam int POS_QOS  = 94;
    localparam int POS_TCI  = 103;
    localparam int POS_TT   = 119;
    localparam int POS_POP  = 146;
    localparam int POS_EOFS = 144;

    localparam logic [15:0] TPID_C = 16'h8100;
    localparam logic [15:0] TPID_S = 16'h88A8;

    typedef enum logic [2:0] {
        ST_PFX, ST_HDR, ST_GAP, ST_MAC, ST_TAG, ST_RPL, ST_BODY, ST_DROP
    } st_e;

    typedef struct packed {
        logic [1:0]        pop;
        logic [1:0]        eofs;
        logic [PORT_W-1:0] port;
        logic              tt;
        logic [15:0]       tci;
        logic [2:0]        qos;
    } fld_t;

    typedef struct packed {
        st_e                      st;
        logic [CNT_W-1:0]         cnt;
        logic [3:0]               gap;
        fld_t                     fld;
        logic [TAG_BYTES-1:0][7:0] hold;
        logic [2:0]               hcnt;
        logic [1:0]               rp;
        logic                     hlast;
        logic                     sbv;
        logic                     vlan;
        logic                     err;
    } st_t;

    // Update the bits of a field that live in header byte k.
    function automatic logic [15:0] pick(input logic [15:0] cur, input int lsb,
                                         input int wid, input int k,
                                         input logic [7:0] b);
        logic [15:0] r;
        r = cur;
        for (int i = 0; i < 16; i++) begin
            if (i < wid && ((HDR_MSB - (lsb + i)) / 8) == k)
                r[i] = b[(lsb + i) % 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/xtr_pfx_check.sv
module xtr_pfx_check #(
    parameter int DMAC_BYTES = 6,
    parameter int ETYPE_POS  = 12
) (
    input  logic [3:0] idx,
    input  logic [7:0] din,
    output logic       ok
);
    localparam logic [7:0] ONES  = 8'hFF;
    localparam logic [7:0] ET_HI = 8'h88;
    localparam logic [7:0] ET_LO = 8'h80;

    always_comb begin
        if (int'(idx) < DMAC_BYTES)          ok = (din == ONES);
        else if (int'(idx) == ETYPE_POS)     ok = (din == ET_HI);
        else if (int'(idx) == ETYPE_POS + 1) ok = (din == ET_LO);
        else                                 ok = 1'b1;
    end
endmodule

// File: rtl/xtr_hdr_capture.sv
module xtr_hdr_capture
    import xtr_pkg::*;
(
    input  logic             en,
    input  logic [CNT_W-1:0] idx,
    input  logic [7:0]       din,
    input  fld_t             cur,
    output fld_t             nxt
);
    always_comb begin
        nxt = cur;
        if (en) begin
            nxt.port = PORT_W'(pick({{(16-PORT_W){1'b0}}, cur.port}, POS_PORT, PORT_W, int'(idx), din));
            nxt.qos  = 3'(pick({13'b0, cur.qos}, POS_QOS, 3, int'(idx), din));
            nxt.tci  = pick(cur.tci, POS_TCI, 16, int'(idx), din);
            nxt.tt   = 1'(pick({15'b0, cur.tt}, POS_TT, 1, int'(idx), din));
            nxt.pop  = 2'(pick({14'b0, cur.pop}, POS_POP, 2, int'(idx), din));
            nxt.eofs = 2'(pick({14'b0, cur.eofs}, POS_EOFS, 2, int'(idx), din));
        end
    end
endmodule

// File: rtl/xtr_hdr_strip.sv
module xtr_hdr_strip
    import xtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [7:0]        m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready,
    input  logic [N_PORTS-1:0] vlan_filt,
    output logic              sb_valid,
    output logic [PORT_W-1:0] sb_port,
    output logic [2:0]        sb_qos,
    output logic              sb_tag_type,
    output logic [15:0]       sb_tci,
    output logic [1:0]        sb_pop,
    output logic [1:0]        sb_eofs,
    output logic              sb_vlan_hdr,
    output logic              frame_err
);
    st_t  q, d;
    fld_t fld_cap;
    logic pfx_ok, beat, rp_end, strip_ok;
    logic [3:0] gap_len;

    xtr_pfx_check u_pfx (
        .idx (q.cnt[3:0]),
        .din (s_tdata),
        .ok  (pfx_ok)
    );

    xtr_hdr_capture u_cap (
        .en  (s_tvalid && q.st == ST_HDR),
        .idx (q.cnt),
        .din (s_tdata),
        .cur (q.fld),
        .nxt (fld_cap)
    );

    // Stream handshake per state.
    always_comb begin
        m_tdata  = s_tdata;
        m_tlast  = s_tlast;
        m_tvalid = 1'b0;
        s_tready = 1'b0;
        rp_end   = ({1'b0, q.rp} == q.hcnt - 3'd1);
        unique case (q.st)
            ST_MAC, ST_BODY: begin
                m_tvalid = s_tvalid;
                s_tready = m_tready;
            end
            ST_RPL: begin
                m_tvalid = 1'b1;
                m_tdata  = q.hold[q.rp];
                m_tlast  = q.hlast && rp_end;
            end
            default: s_tready = 1'b1;
        endcase
    end

    assign beat     = s_tvalid && s_tready;
    assign strip_ok = vlan_filt[q.fld.port] &&
                      ({q.hold[0], q.hold[1]} == (q.fld.tt ? TPID_S : TPID_C));

    always_comb begin
        if (q.fld.pop == 2'd0 && q.fld.eofs == 2'd0) gap_len = 4'(GAP_TWO);
        else if (q.fld.pop == 2'd3)                  gap_len = 4'(TAG_BYTES);
        else                                         gap_len = 4'd0;
    end

    always_comb begin
        d     = q;
        d.err = 1'b0;
        unique case (q.st)
            ST_PFX: if (beat) begin
                if (!pfx_ok) begin
                    d.err = 1'b1;
                    d.cnt = '0;
                    d.st  = s_tlast ? ST_PFX : ST_DROP;
                end else if (s_tlast) begin
                    d.err = 1'b1;
                    d.cnt = '0;
                end else if (int'(q.cnt) == PFX_BYTES - 1) begin
                    d.st  = ST_HDR;
                    d.cnt = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_HDR: if (beat) begin
                d.fld = fld_cap;
                if (s_tlast) begin
                    d.err = 1'b1;
                    d.st  = ST_PFX;
                    d.cnt = '0;
                end else if (int'(q.cnt) == HDR_BYTES - 1) begin
                    d.cnt = '0;
                    d.gap = gap_len;
                    if (gap_len == 4'd0) begin
                        d.st  = ST_MAC;
                        d.sbv = 1'b1;
                    end else d.st = ST_GAP;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_GAP: if (beat) begin
                if (s_tlast) begin
                    d.err = 1'b1;
                    d.st  = ST_PFX;
                    d.cnt = '0;
                end else if (q.cnt == CNT_W'(q.gap - 4'd1)) begin
                    d.st  = ST_MAC;
                    d.sbv = 1'b1;
                    d.cnt = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_MAC: if (beat) begin
                if (s_tlast) begin
                    d.st = ST_PFX; d.cnt = '0; d.sbv = 1'b0; d.vlan = 1'b0;
                end else if (int'(q.cnt) == MAC_BYTES - 1) begin
                    d.st  = ST_TAG;
                    d.cnt = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_TAG: if (beat) begin
                d.hold[q.cnt[1:0]] = s_tdata;
                d.rp = '0;
                if (s_tlast) begin
                    d.st    = ST_RPL;
                    d.hcnt  = 3'(q.cnt[1:0]) + 3'd1;
                    d.hlast = 1'b1;
                end else if (int'(q.cnt) == TAG_BYTES - 1) begin
                    if (strip_ok) begin
                        d.st   = ST_BODY;
                        d.vlan = 1'b1;
                    end else begin
                        d.st    = ST_RPL;
                        d.hcnt  = 3'(TAG_BYTES);
                        d.hlast = 1'b0;
                    end
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_RPL: if (m_tready) begin
                if (rp_end) begin
                    d.cnt = '0;
                    if (q.hlast) begin
                        d.st = ST_PFX; d.sbv = 1'b0; d.vlan = 1'b0;
                    end else d.st = ST_BODY;
                end else d.rp = q.rp + 1'b1;
            end
            ST_BODY: if (beat && s_tlast) begin
                d.st = ST_PFX; d.cnt = '0; d.sbv = 1'b0; d.vlan = 1'b0;
            end
            ST_DROP: if (beat && s_tlast) begin
                d.st  = ST_PFX;
                d.cnt = '0;
            end
            default: d.st = ST_PFX;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sb_valid    = q.sbv;
    assign sb_port     = q.fld.port;
    assign sb_qos      = q.fld.qos;
    assign sb_tag_type = q.fld.tt;
    assign sb_tci      = q.fld.tci;
    assign sb_pop      = q.fld.pop;
    assign sb_eofs     = q.fld.eofs;
    assign sb_vlan_hdr = q.vlan;
    assign frame_err   = q.err;

    assert_out_has_sideband_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> sb_valid);

    assert_sideband_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_valid && !(m_tvalid && m_tready && m_tlast)) |=>
        (sb_valid && $stable(sb_port) && $stable(sb_tci) && $stable(sb_qos) &&
         $stable(sb_tag_type) && $stable(sb_pop) && $stable(sb_eofs)));

    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    assert_err_outside_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!sb_valid && !m_tvalid));

    assert_vlan_within_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sb_vlan_hdr |-> sb_valid);
endmodule

// File: tb/xtr_hdr_strip_bench.sv
module xtr_hdr_strip_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] s_tdata = '0, m_tdata;
    logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
    logic m_tvalid, m_tlast, m_tready = 1'b1;
    logic [15:0] vlan_filt = 16'h00F0;
    logic sb_valid, sb_tag_type, sb_vlan_hdr, frame_err;
    logic [3:0] sb_port;
    logic [2:0] sb_qos;
    logic [15:0] sb_tci;
    logic [1:0] sb_pop, sb_eofs;

    xtr_hdr_strip u_xtr_hdr_strip (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, err_seen = 0;
    bit bp_en = 0, finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] exp_q[$];
    logic [3:0] e_port; logic [2:0] e_qos; logic e_tt; logic [15:0] e_tci;
    logic [1:0] e_pop, e_eofs; logic e_vlan;
    string cur_req = "R1";

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exv);
        end
    endtask

    initial forever begin
        @(negedge clk);
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_tready <= bp_en ? lfsr[0] : 1'b1;
    end

    // Output monitor against the behavioural expectation queue.
    initial forever begin
        @(negedge clk); #2;
        if (rst_n && frame_err) err_seen++;
        if (rst_n && m_tvalid && m_tready) begin
            if (exp_q.size() == 0) begin
                check(0, cur_req, "unexpected output byte R1", m_tdata, 0);
            end else begin
                logic [7:0] e;
                bit el;
                el = (exp_q.size() == 1);
                e = exp_q.pop_front();
                check(m_tdata == e && m_tlast == el, cur_req, "data/last R1 R9",
                      {m_tlast, m_tdata}, {el, e});
                check(sb_valid && sb_port == e_port && sb_qos == e_qos && sb_tt_ok() &&
                      sb_tci == e_tci && sb_pop == e_pop && sb_eofs == e_eofs,
                      "R3", "sideband R5",
                      {sb_valid, sb_port, sb_qos, sb_tci, sb_pop, sb_eofs},
                      {1'b1, e_port, e_qos, e_tci, e_pop, e_eofs});
                if (el) check(sb_vlan_hdr == e_vlan, e_vlan ? "R6" : "R7",
                              "tag removed flag", sb_vlan_hdr, e_vlan);
            end
        end
    end

    function automatic bit sb_tt_ok();
        return sb_tag_type == e_tt;
    endfunction

    task automatic send(input logic [7:0] st[$]);
        for (int i = 0; i < st.size(); i++) begin
            @(negedge clk);
            s_tdata = st[i]; s_tvalid = 1'b1; s_tlast = (i == st.size() - 1);
            #1;
            while (!s_tready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    // tagmode: 0 none, 1 matching protocol ID, 2 the other protocol ID
    task automatic frame(input string rq, input int bad, input logic [1:0] pop,
                         input logic [1:0] eofs, input logic tt, input logic [3:0] port,
                         input logic [15:0] tci, input logic [2:0] qos,
                         input int eth_len, input int tagmode, input int cut);
        logic [7:0] st[$];
        logic [7:0] eth[$];
        logic [223:0] h;
        logic [15:0] tp, other;
        int gap, e0;
        bit expect_err, strip;
        tp = tt ? 16'h88A8 : 16'h8100;
        other = tt ? 16'h8100 : 16'h88A8;
        st = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFE, 8'hFF,
               8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h88, 8'h80, 8'h00, 8'h11};
        if (bad == 1) st[12] = 8'h89;
        if (bad == 2) st[3] = 8'h7F;
        h = {224{1'b1}} ^ {28{8'h5A}};
        h[143:140] = port; h[96:94] = qos; h[118:103] = tci; h[119] = tt;
        h[147:146] = pop; h[145:144] = eofs;
        for (int i = 0; i < 28; i++) st.push_back(h[223 - 8*i -: 8]);
        gap = (pop == 0 && eofs == 0) ? 8 : (pop == 3) ? 4 : 0;
        for (int i = 0; i < gap; i++) st.push_back(8'hEE);
        for (int i = 0; i < eth_len; i++) eth.push_back(8'(i * 7 + 3));
        if (tagmode != 0 && eth_len > 13) begin
            eth[12] = tagmode == 1 ? tp[15:8] : other[15:8];
            eth[13] = tagmode == 1 ? tp[7:0] : other[7:0];
        end
        foreach (eth[i]) st.push_back(eth[i]);
        if (cut >= 0) while (st.size() > cut) void'(st.pop_back());
        expect_err = (bad != 0) || (st.size() <= 44 + gap);
        strip = !expect_err && vlan_filt[port] && eth_len >= 17 &&
                {eth[12], eth[13]} == tp;
        exp_q.delete();
        if (!expect_err) begin
            foreach (eth[i]) if (!(strip && i >= 12 && i <= 15)) exp_q.push_back(eth[i]);
        end
        e_port = port; e_qos = qos; e_tt = tt; e_tci = tci; e_pop = pop;
        e_eofs = eofs; e_vlan = strip; cur_req = rq;
        e0 = err_seen;
        send(st);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, rq, "bytes missing at frame end R1", exp_q.size(), 0);
        check(err_seen - e0 == int'(expect_err), expect_err ? (bad != 0 ? "R2" : "R8") : rq,
              "error pulses", err_seen - e0, int'(expect_err));
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!m_tvalid && !sb_valid && !frame_err && !sb_vlan_hdr, "R5",
              "reset state", {m_tvalid, sb_valid, frame_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(s_tready == 1'b1, "R1", "ready after reset", s_tready, 1);
        frame("R4", 0, 2'd1, 2'd0, 1'b0, 4'd2, 16'h1234, 3'd5, 30, 0, -1);
        frame("R4", 0, 2'd0, 2'd0, 1'b0, 4'd9, 16'hBEEF, 3'd2, 25, 0, -1);
        frame("R4", 0, 2'd3, 2'd1, 1'b1, 4'd11, 16'h0F0F, 3'd7, 20, 0, -1);
        frame("R4", 0, 2'd0, 2'd2, 1'b0, 4'd1, 16'hA5C3, 3'd1, 18, 0, -1);
        frame("R6", 0, 2'd1, 2'd0, 1'b0, 4'd4, 16'h0064, 3'd3, 40, 1, -1);
        frame("R6", 0, 2'd3, 2'd0, 1'b1, 4'd7, 16'hE00A, 3'd6, 24, 1, -1);
        frame("R6", 0, 2'd2, 2'd1, 1'b0, 4'd5, 16'h0001, 3'd0, 17, 1, -1);
        frame("R7", 0, 2'd1, 2'd0, 1'b1, 4'd5, 16'h0123, 3'd4, 30, 2, -1);
        frame("R7", 0, 2'd1, 2'd0, 1'b0, 4'd3, 16'h0222, 3'd4, 30, 1, -1);
        frame("R7", 0, 2'd1, 2'd0, 1'b0, 4'd6, 16'h0333, 3'd1, 14, 1, -1);
        frame("R7", 0, 2'd1, 2'd0, 1'b0, 4'd6, 16'h0444, 3'd1, 16, 1, -1);
        frame("R1", 0, 2'd2, 2'd0, 1'b0, 4'd0, 16'h0555, 3'd2, 5, 0, -1);
        frame("R2", 1, 2'd1, 2'd0, 1'b0, 4'd2, 16'h0666, 3'd2, 30, 0, -1);
        frame("R2", 2, 2'd1, 2'd0, 1'b0, 4'd2, 16'h0777, 3'd2, 30, 0, -1);
        frame("R8", 0, 2'd1, 2'd0, 1'b0, 4'd2, 16'h0888, 3'd2, 30, 0, 30);
        frame("R8", 0, 2'd0, 2'd0, 1'b0, 4'd2, 16'h0999, 3'd2, 30, 0, 47);
        frame("R8", 0, 2'd0, 2'd0, 1'b0, 4'd2, 16'h0AAA, 3'd2, 30, 0, 52);
        frame("R8", 0, 2'd1, 2'd0, 1'b0, 4'd2, 16'h0BBB, 3'd2, 30, 0, 10);
        bp_en = 1;
        frame("R9", 0, 2'd1, 2'd0, 1'b0, 4'd4, 16'h0CCC, 3'd3, 40, 1, -1);
        frame("R9", 0, 2'd0, 2'd0, 1'b1, 4'd8, 16'h0DDD, 3'd5, 33, 2, -1);
        frame("R9", 0, 2'd1, 2'd0, 1'b0, 4'd6, 16'h0EEE, 3'd1, 15, 1, -1);
        frame("R9", 0, 2'd3, 2'd0, 1'b1, 4'd7, 16'h0FFF, 3'd6, 60, 1, -1);
        bp_en = 0;
        frame("R3", 0, 2'd2, 2'd3, 1'b1, 4'd15, 16'hFFFF, 3'd7, 20, 0, -1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule